// File: doc/BRIEF.md
# Serial Address and Command Word Receiver

This block takes 8-bit words from a host over a three-wire serial link: an active-low select, a shift clock and a data line. All three pins are brought into the system clock domain through flop synchronisers, and their edges are found there. Bits are shifted in most significant first on each rising shift-clock edge while select is low. A word is taken at the falling edge of the eighth shift-clock pulse.

The first word of each select-low frame sets the role of the rest of the frame. A first word tagged as an address loads a display write pointer. Every later word in that frame then becomes a display data write at the pointer, and the pointer steps up after each write. A first word tagged as a command produces one command write, and the rest of the frame is thrown away. Each decoded word leaves the block as a single-cycle strobe with its byte. A register file or display latch downstream acts on the strobes.

Top module: `frame_word_rx`

## Requirements
- R1: Bits are sampled on rising shift-clock edges only while select is low, most significant bit first, so the first bit sent lands in bit 7 of the byte.
- R2: A first word whose bits 7:6 are 01 gives one `addr_ld_o` pulse, and `disp_addr_o` carries that word's bits 5:0.
- R3: A first word with bit 7 set (tag 10 or 11) gives one `cmd_we_o` pulse, and `cmd_data_o` carries the full byte. `cmd_data_o` changes only together with that pulse.
- R4: After a command first word, no later word in the same frame produces any strobe.
- R5: After an address first word, each further complete word gives one `disp_we_o` pulse carrying that byte. The first write goes to the loaded address, and each later write goes one address higher, wrapping from 63 to 0.
- R6: A first word whose bits 7:6 are 00 produces no strobe, and neither does any later word in that frame.
- R7: If select rises after 1 to 7 bits of a word, that word is dropped with no strobe, and it does not disturb the classification of the next frame.
- R8: Shift-clock activity while select is high has no effect. The shift clock may be high when select falls, and each new frame classifies its first word afresh.
- R9: While `rst` is high, all strobes, bytes and addresses are driven to zero. After reset, a partial word received before it has no effect.
- R10: Each strobe lasts one system clock cycle, and at most one of the three strobes is high in any cycle.
- R11: A complete word is committed at the eighth shift-clock falling edge, before select rises.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the shift clock rate |
| rst | input | 1 | Synchronous active-high reset |
| sel_n_i | input | 1 | Frame select, active low, asynchronous |
| sclk_i | input | 1 | Shift clock, asynchronous |
| sdi_i | input | 1 | Serial data, MSB first, asynchronous |
| cmd_we_o | output | 1 | Command write strobe |
| cmd_data_o | output | 8 | Command byte |
| addr_ld_o | output | 1 | Address load strobe |
| disp_we_o | output | 1 | Display data write strobe |
| disp_data_o | output | 8 | Display data byte |
| disp_addr_o | output | 6 | Loaded address on `addr_ld_o`, write address on `disp_we_o` |

## Verification
A table of frames covers each first-word tag: address, command with bit 6 low and high, and the 00 tag. Each is followed by zero to four trailing words, so the bench can tell a frame that streams data from one that discards it. One address frame starts at 62 so that the pointer wraps. Directed frames cut words short at select rise and toggle the shift clock with select high. They also start a frame with the shift clock high and reset in the middle of a word. Each of these is followed by a clean frame, which shows whether any stale bits or stale frame role survived.

// File: rtl/frame_rx_pkg.sv
package frame_rx_pkg;

    typedef enum logic [1:0] {
        FR_FIRST,
        FR_DATA,
        FR_SKIP
    } frame_st_e;

    typedef enum logic [1:0] {
        WK_NONE,
        WK_ADDR,
        WK_CMD
    } word_kind_e;

    typedef struct packed {
        logic cs_n;
        logic sck;
        logic sdi;
    } pins_t;

    function automatic word_kind_e classify(input logic [1:0] tag);
        if (tag[1])      return WK_CMD;
        else if (tag[0]) return WK_ADDR;
        else             return WK_NONE;
    endfunction

endpackage

// File: rtl/sig_sync.sv
module sig_sync #(
    parameter int W = 3,
    parameter int STAGES = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    for (genvar k = 0; k < STAGES; k++) begin : g_stage
        if (k == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) stg[k] <= RST_VAL;
                else     stg[k] <= d;
            end
        end else begin : g_tail
            always_ff @(posedge clk) begin
                if (rst) stg[k] <= RST_VAL;
                else     stg[k] <= stg[k-1];
            end
        end
    end

    assign q = stg[STAGES-1];
endmodule

// File: rtl/word_shifter.sv
module word_shifter #(
    parameter int WORD_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_act,
    input  logic              frame_start,
    input  logic              frame_end,
    input  logic              sck_rise,
    input  logic              sck_fall,
    input  logic              sdi,
    output logic              word_valid,
    output logic [WORD_W-1:0] word
);
    localparam int CNT_W = $clog2(WORD_W + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(WORD_W);
    localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

    logic [CNT_W-1:0]  cnt_q;
    logic [WORD_W-1:0] sh_q;

    assign word_valid = (cnt_q == CNT_FULL) && ((sel_act && sck_fall) || frame_end);
    assign word       = sh_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
            sh_q  <= '0;
        end else if (frame_start || frame_end || word_valid) begin
            cnt_q <= '0;
        end else if (sel_act && sck_rise && cnt_q != CNT_FULL) begin
            sh_q  <= {sh_q[WORD_W-2:0], sdi};
            cnt_q <= cnt_q + CNT_ONE;
        end
    end
endmodule

// File: rtl/frame_ctrl.sv
module frame_ctrl
    import frame_rx_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word,
    output logic              cmd_we,
    output logic [WORD_W-1:0] cmd_data,
    output logic              addr_ld,
    output logic              disp_we,
    output logic [WORD_W-1:0] disp_data,
    output logic [ADDR_W-1:0] disp_addr
);
    localparam logic [ADDR_W-1:0] PTR_ONE = ADDR_W'(1);

    frame_st_e         st_q;
    logic [ADDR_W-1:0] ptr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q      <= FR_FIRST;
            ptr_q     <= '0;
            cmd_we    <= 1'b0;
            cmd_data  <= '0;
            addr_ld   <= 1'b0;
            disp_we   <= 1'b0;
            disp_data <= '0;
            disp_addr <= '0;
        end else begin
            cmd_we  <= 1'b0;
            addr_ld <= 1'b0;
            disp_we <= 1'b0;
            if (frame_start) begin
                st_q <= FR_FIRST;
            end else if (word_valid) begin
                case (st_q)
                    FR_FIRST: begin
                        case (classify(word[WORD_W-1 -: 2]))
                            WK_ADDR: begin
                                addr_ld   <= 1'b1;
                                disp_addr <= word[ADDR_W-1:0];
                                ptr_q     <= word[ADDR_W-1:0];
                                st_q      <= FR_DATA;
                            end
                            WK_CMD: begin
                                cmd_we   <= 1'b1;
                                cmd_data <= word;
                                st_q     <= FR_SKIP;
                            end
                            default: st_q <= FR_SKIP;
                        endcase
                    end
                    FR_DATA: begin
                        disp_we   <= 1'b1;
                        disp_data <= word;
                        disp_addr <= ptr_q;
                        ptr_q     <= ptr_q + PTR_ONE;
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/frame_word_rx.sv
module frame_word_rx
    import frame_rx_pkg::*;
#(
    parameter int WORD_W = 8,
    parameter int ADDR_W = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              sel_n_i,
    input  logic              sclk_i,
    input  logic              sdi_i,
    output logic              cmd_we_o,
    output logic [WORD_W-1:0] cmd_data_o,
    output logic              addr_ld_o,
    output logic              disp_we_o,
    output logic [WORD_W-1:0] disp_data_o,
    output logic [ADDR_W-1:0] disp_addr_o
);
    localparam pins_t PINS_IDLE = '{cs_n: 1'b1, sck: 1'b0, sdi: 1'b0};

    pins_t raw, syn, prv;
    logic  frame_start, frame_end, sck_rise, sck_fall;
    logic  word_valid;
    logic [WORD_W-1:0] word;

    assign raw = '{cs_n: sel_n_i, sck: sclk_i, sdi: sdi_i};

    sig_sync #(
        .W($bits(pins_t)),
        .STAGES(SYNC_STAGES),
        .RST_VAL(PINS_IDLE)
    ) i_sync (
        .clk(clk),
        .rst(rst),
        .d(raw),
        .q(syn)
    );

    always_ff @(posedge clk) begin
        if (rst) prv <= PINS_IDLE;
        else     prv <= syn;
    end

    assign frame_start = prv.cs_n & ~syn.cs_n;
    assign frame_end   = ~prv.cs_n & syn.cs_n;
    assign sck_rise    = syn.sck & ~prv.sck;
    assign sck_fall    = ~syn.sck & prv.sck;

    word_shifter #(.WORD_W(WORD_W)) i_shift (
        .clk(clk),
        .rst(rst),
        .sel_act(~syn.cs_n),
        .frame_start(frame_start),
        .frame_end(frame_end),
        .sck_rise(sck_rise),
        .sck_fall(sck_fall),
        .sdi(syn.sdi),
        .word_valid(word_valid),
        .word(word)
    );

    frame_ctrl #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_ctrl (
        .clk(clk),
        .rst(rst),
        .frame_start(frame_start),
        .word_valid(word_valid),
        .word(word),
        .cmd_we(cmd_we_o),
        .cmd_data(cmd_data_o),
        .addr_ld(addr_ld_o),
        .disp_we(disp_we_o),
        .disp_data(disp_data_o),
        .disp_addr(disp_addr_o)
    );
endmodule

// File: rtl/frame_word_rx_chk.sv
module frame_word_rx_chk #(
    parameter int WORD_W = 8,
    parameter int ADDR_W = 6
) (
    input logic              clk,
    input logic              rst,
    input logic              cmd_we_o,
    input logic [WORD_W-1:0] cmd_data_o,
    input logic              addr_ld_o,
    input logic              disp_we_o,
    input logic [ADDR_W-1:0] disp_addr_o
);
    localparam logic [ADDR_W-1:0] STEP = ADDR_W'(1);

    logic              armed_q;
    logic              rst_d;
    logic [ADDR_W-1:0] nxt_q;

    always_ff @(posedge clk) begin
        rst_d <= rst;
        if (rst) begin
            armed_q <= 1'b0;
            nxt_q   <= '0;
        end else if (addr_ld_o) begin
            armed_q <= 1'b1;
            nxt_q   <= disp_addr_o;
        end else if (cmd_we_o) begin
            armed_q <= 1'b0;
        end else if (disp_we_o) begin
            nxt_q <= disp_addr_o + STEP;
        end
    end

    // R9: the cycle after reset is sampled, no strobe is out
    always_ff @(posedge clk) begin
        if (rst_d) begin
            a_r9_quiet_in_reset: assert (!cmd_we_o && !addr_ld_o && !disp_we_o)
                else $error("strobe during reset");
        end
    end

    // R10
    a_r10_onehot_strobes: assert property (@(posedge clk) disable iff (rst)
        $onehot0({cmd_we_o, addr_ld_o, disp_we_o}));

    // R10
    a_r10_disp_single_cycle: assert property (@(posedge clk) disable iff (rst)
        disp_we_o |=> !disp_we_o);

    // R4
    a_r4_no_data_after_cmd: assert property (@(posedge clk) disable iff (rst)
        disp_we_o |-> armed_q);

    // R5
    a_r5_addr_sequence: assert property (@(posedge clk) disable iff (rst)
        (disp_we_o && armed_q) |-> (disp_addr_o == nxt_q));

    // R3
    a_r3_cmd_data_held: assert property (@(posedge clk) disable iff (rst)
        !$stable(cmd_data_o) |-> cmd_we_o);
endmodule

bind frame_word_rx frame_word_rx_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) i_chk (
    .clk(clk),
    .rst(rst),
    .cmd_we_o(cmd_we_o),
    .cmd_data_o(cmd_data_o),
    .addr_ld_o(addr_ld_o),
    .disp_we_o(disp_we_o),
    .disp_addr_o(disp_addr_o)
);

// File: tb/test_frame_word_rx.sv
module test_frame_word_rx;
    localparam int HALF = 5;
    localparam int NV = 6;
    // {first word, trailing word count}
    localparam logic [15:0] VEC [NV] = '{
        16'h4503, 16'h8002, 16'hC300, 16'h7E04, 16'h1202, 16'h4001
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic sel_n = 1'b1, sclk = 1'b0, sdi = 1'b0;
    logic       cmd_we, addr_ld, disp_we;
    logic [7:0] cmd_data, disp_data;
    logic [5:0] disp_addr;

    int n_tests = 0, n_fail = 0;
    int cmd_cnt = 0, addr_cnt = 0, disp_cnt = 0;
    int excl_err = 0, pulse_err = 0;
    logic [7:0] last_cmd = '0;
    logic [5:0] last_addr = '0;
    logic [7:0] cap_data [256];
    logic [5:0] cap_addr [256];
    logic prev_disp = 1'b0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    frame_word_rx i_frame_word_rx (
        .clk(clk), .rst(rst), .sel_n_i(sel_n), .sclk_i(sclk), .sdi_i(sdi),
        .cmd_we_o(cmd_we), .cmd_data_o(cmd_data), .addr_ld_o(addr_ld),
        .disp_we_o(disp_we), .disp_data_o(disp_data), .disp_addr_o(disp_addr)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if ($countones({cmd_we, addr_ld, disp_we}) > 1) excl_err++;
            if (disp_we && prev_disp) pulse_err++;
            if (cmd_we) begin cmd_cnt++; last_cmd = cmd_data; end
            if (addr_ld) begin addr_cnt++; last_addr = disp_addr; end
            if (disp_we) begin
                cap_data[disp_cnt % 256] = disp_data;
                cap_addr[disp_cnt % 256] = disp_addr;
                disp_cnt++;
            end
        end
        prev_disp = disp_we;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_bits(input logic [7:0] w, input int nb);
        for (int b = 0; b < nb; b++) begin
            sdi = w[7-b];
            tick(HALF);
            sclk = 1'b1;
            tick(HALF);
            sclk = 1'b0;
        end
        tick(HALF);
    endtask

    task automatic open_frame();
        sel_n = 1'b0;
        tick(6);
    endtask

    task automatic close_frame();
        tick(6);
        sel_n = 1'b1;
        tick(12);
    endtask

    function automatic logic [7:0] pat(input int i, input int j);
        return 8'((165 ^ (j * 29)) + i * 3);
    endfunction

    initial begin
        tick(4);
        // R9: outputs zero during reset
        check(!cmd_we && !addr_ld && !disp_we && cmd_data == 0 && disp_data == 0 && disp_addr == 0,
              "R9 reset state", {cmd_we, addr_ld, disp_we}, 0);
        rst = 1'b0;
        tick(4);

        // R1 R2 R3 R4 R5 R6: table of frames
        for (int i = 0; i < NV; i++) begin
            logic [7:0] first;
            int n, c0, a0, d0, exp_c, exp_a, exp_d;
            first = VEC[i][15:8];
            n = int'(VEC[i][7:0]);
            c0 = cmd_cnt; a0 = addr_cnt; d0 = disp_cnt;
            open_frame();
            send_bits(first, 8);
            for (int j = 0; j < n; j++) send_bits(pat(i, j), 8);
            close_frame();
            exp_c = first[7] ? 1 : 0;
            exp_a = (first[7:6] == 2'b01) ? 1 : 0;
            exp_d = (first[7:6] == 2'b01) ? n : 0;
            check(cmd_cnt - c0 == exp_c, "R3/R6 command count", cmd_cnt - c0, exp_c);
            check(addr_cnt - a0 == exp_a, "R2/R6 address count", addr_cnt - a0, exp_a);
            check(disp_cnt - d0 == exp_d, "R4/R5/R6 data count", disp_cnt - d0, exp_d);
            if (exp_c == 1) check(last_cmd == first, "R1 R3 command byte", last_cmd, first);
            if (exp_a == 1) check(last_addr == first[5:0], "R2 loaded address", last_addr, first[5:0]);
            if (exp_d == n) begin
                for (int j = 0; j < n; j++) begin
                    logic [5:0] ea;
                    ea = 6'(first[5:0] + j);
                    check(cap_data[(d0 + j) % 256] == pat(i, j), "R5 data byte", cap_data[(d0 + j) % 256], pat(i, j));
                    check(cap_addr[(d0 + j) % 256] == ea, "R5 write address", cap_addr[(d0 + j) % 256], ea);
                end
            end
        end

        // R11: word taken before select rises
        begin
            int d0;
            d0 = disp_cnt;
            open_frame();
            send_bits(8'h41, 8);
            send_bits(8'h3C, 8);
            tick(6);
            check(disp_cnt - d0 == 1, "R11 commit at eighth fall", disp_cnt - d0, 1);
            close_frame();
        end

        // R7: partial trailing word dropped
        begin
            int d0;
            d0 = disp_cnt;
            open_frame();
            send_bits(8'h50, 8);
            send_bits(8'h77, 8);
            send_bits(8'hFF, 5);
            close_frame();
            check(disp_cnt - d0 == 1, "R7 partial data word dropped", disp_cnt - d0, 1);
        end

        // R7: partial first word dropped, next frame clean
        begin
            int c0, a0;
            c0 = cmd_cnt; a0 = addr_cnt;
            open_frame();
            send_bits(8'h40, 3);
            close_frame();
            check(cmd_cnt == c0 && addr_cnt == a0, "R7 partial first word", cmd_cnt - c0 + addr_cnt - a0, 0);
            open_frame();
            send_bits(8'h81, 8);
            close_frame();
            check(cmd_cnt - c0 == 1 && last_cmd == 8'h81, "R7 following command", last_cmd, 8'h81);
        end

        // R8: shift clock with select high ignored; frame opened with SCK high
        begin
            int c0, a0, d0;
            c0 = cmd_cnt; a0 = addr_cnt; d0 = disp_cnt;
            send_bits(8'hC5, 8);
            check(cmd_cnt == c0 && addr_cnt == a0 && disp_cnt == d0, "R8 idle clocks ignored",
                  cmd_cnt - c0 + addr_cnt - a0 + disp_cnt - d0, 0);
            sclk = 1'b1;
            tick(HALF);
            open_frame();
            sclk = 1'b0;
            tick(HALF);
            send_bits(8'h42, 8);
            send_bits(8'h99, 8);
            close_frame();
            check(addr_cnt - a0 == 1 && last_addr == 6'h02, "R8 address after SCK-high start", last_addr, 2);
            check(disp_cnt - d0 == 1 && cap_data[d0 % 256] == 8'h99, "R8 data after SCK-high start",
                  cap_data[d0 % 256], 8'h99);
        end

        // R9: reset in the middle of a word
        begin
            int c0, a0;
            open_frame();
            send_bits(8'h40, 4);
            rst = 1'b1;
            tick(3);
            check(!cmd_we && !addr_ld && !disp_we && disp_addr == 0 && cmd_data == 0,
                  "R9 outputs cleared", {cmd_we, addr_ld, disp_we}, 0);
            rst = 1'b0;
            c0 = cmd_cnt; a0 = addr_cnt;
            tick(6);
            send_bits(8'h83, 8);
            close_frame();
            check(cmd_cnt - c0 == 1 && last_cmd == 8'h83, "R9 partial bits discarded", last_cmd, 8'h83);
            check(addr_cnt == a0, "R9 no address after reset", addr_cnt - a0, 0);
        end

        // R10
        check(excl_err == 0, "R10 strobes exclusive", excl_err, 0);
        check(pulse_err == 0, "R10 single-cycle strobe", pulse_err, 0);

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule